// File: doc/BRIEF.md
# Heterogeneous Wire-Class Link Steering

This block models a single link between two execution clusters. The link is built from three parallel classes of wire. A fast class is narrow and quick. A baseline class carries a full data word. A slow class is wide and low-power. The sender presents one transfer per cycle and labels it with a kind code. A steering stage looks at the kind and at the payload's magnitude and picks the class. The transfer then moves through that class's fixed-length delay line and appears on the class's own output lane. The lane shows the payload, the kind, and a stamp of the cycle in which the transfer arrived.

Latencies are parameters of the build. A crossbar build uses one set of per-class latencies. A ring build multiplies per-hop latencies by a hop count. The three output lanes are independent. Transfers on one class stay in order, while transfers on different classes may overtake each other.

The receiver can stall each lane separately. When the class the steering logic picks is stalled, the sender is held off through its valid/ready handshake. The transfer is never moved to another class.

Top module: `hetero_wire_link`

## Requirements
- R1: After synchronous reset, all three `out_valid` bits are 0 and `in_ready` is 1.
- R2: The kind code is 3 bits: 0 generic, 1 narrow integer operand, 2 low-order address bits, 3 operand already ready at dispatch, 4 store data, and 5 to 7 treated as generic. A kind-1 transfer whose payload is below 2^10 goes to lane 0 (fast). Any other kind-1 transfer goes to lane 1 (baseline).
- R3: A kind-2 transfer whose payload is below 2^18 goes to lane 0. Any other kind-2 transfer goes to lane 1.
- R4: Kinds 3 and 4 always go to lane 2 (low-power). Kinds 0, 5, 6 and 7 always go to lane 1.
- R5: In a crossbar build, a transfer accepted in cycle t is visible on its lane in cycle t+1 on lane 0, t+2 on lane 1 and t+3 on lane 2, provided that lane is not stalled.
- R6: In a ring build with H hops, the lane 0, 1 and 2 latencies are 2H, 4H and 6H cycles.
- R7: The lane carries the sender's payload and kind unchanged. Lane 0 carries only 18 payload bits, so its `out_data` bits above bit 17 are always 0.
- R8: A cycle counter is 0 in the first cycle after reset and adds 1 each cycle. `out_stamp` of a lane equals the counter's value in the cycle the transfer first appears on that lane.
- R9: A lane whose `out_valid` is 1 while its `out_ready` is 0 stalls its whole class. The output holds the same data, kind and stamp. `in_ready` is 0 exactly when the class chosen for the current request is stalled.
- R10: A request held off by a stalled class is not sent on any other lane. It is accepted as soon as its class can move.
- R11: Transfers on the same lane leave in the order they were accepted. A later transfer on a faster lane may appear before an earlier one on a slower lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sender has a transfer |
| in_ready | output | 1 | Chosen class can take the transfer this cycle |
| in_kind | input | 3 | Transfer kind code |
| in_data | input | DATA_W | Payload |
| out_ready | input | 3 | Per-lane receiver ready |
| out_valid | output | 3 | Per-lane arrival valid |
| out_kind | output | 3x3 | Per-lane kind code |
| out_data | output | 3xDATA_W | Per-lane payload, zero-extended |
| out_stamp | output | 3xTS_W | Per-lane arrival cycle stamp |

## Verification
A transfer accepted in cycle t is due on its lane in cycle t+L. L is 1, 2 or 3 in the crossbar build and 4, 8 or 12 in the two-hop ring build. The bench applies one transfer at a time. It then samples every lane at each falling edge for cycles t+1 onward and records the first cycle in which an arrival appears. It compares that cycle, the lane, the payload and the stamp against values it computes from the kind, the payload and its own cycle count. In the stall and overtaking scenarios, each lane is sampled in the exact cycle in which the arrival order requires a value or no value.

// File: rtl/link_pkg.sv
package link_pkg;

  localparam int NUM_CLASSES = 3;
  localparam int CLS_FAST    = 0;
  localparam int CLS_BASE    = 1;
  localparam int CLS_SLOW    = 2;
  localparam int KIND_W      = 3;

  typedef enum logic [KIND_W-1:0] {
    KIND_GENERIC   = 3'd0,
    KIND_NARROW    = 3'd1,
    KIND_ADDR_LOW  = 3'd2,
    KIND_READY_OPN = 3'd3,
    KIND_STORE     = 3'd4
  } xfer_kind_e;

  // Per-class latency: fast=1, base=2, slow=3 units; a ring hop costs two units.
  function automatic int class_latency(input int cls, input bit ring, input int hops);
    int unit_lat;
    unit_lat = cls + 1;
    return ring ? (2 * unit_lat * hops) : unit_lat;
  endfunction

endpackage

// File: rtl/link_steer.sv
module link_steer
  import link_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int FAST_W   = 18,
  parameter int NARROW_W = 10
) (
  input  logic [KIND_W-1:0]      kind,
  input  logic [DATA_W-1:0]      data,
  output logic [NUM_CLASSES-1:0] cls_onehot
);

  logic fits_narrow;
  logic fits_fast;

  assign fits_narrow = (data >> NARROW_W) == '0;
  assign fits_fast   = (data >> FAST_W) == '0;

  always_comb begin
    cls_onehot = '0;
    case (kind)
      KIND_NARROW:    cls_onehot[fits_narrow ? CLS_FAST : CLS_BASE] = 1'b1;
      KIND_ADDR_LOW:  cls_onehot[fits_fast ? CLS_FAST : CLS_BASE] = 1'b1;
      KIND_READY_OPN,
      KIND_STORE:     cls_onehot[CLS_SLOW] = 1'b1;
      default:        cls_onehot[CLS_BASE] = 1'b1;
    endcase
  end

endmodule

// File: rtl/link_class_pipe.sv
module link_class_pipe #(
  parameter int W     = 21,
  parameter int DEPTH = 1,
  parameter int TS_W  = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [W-1:0]    push_payload,
  input  logic [TS_W-1:0] now_next,
  input  logic            pop_ready,
  output logic            can_accept,
  output logic            pop_valid,
  output logic [W-1:0]    pop_payload,
  output logic [TS_W-1:0] pop_stamp
);

  logic [W-1:0]     stage_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [TS_W-1:0]  stamp_q;
  logic             advance;

  assign advance    = !(vld_q[DEPTH-1] && !pop_ready);
  assign can_accept = advance;

  always_ff @(posedge clk) begin
    if (advance) begin
      stage_q[0] <= push_payload;
      for (int i = 1; i < DEPTH; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
      stamp_q <= now_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (advance) begin
      vld_q[0] <= push;
      for (int i = 1; i < DEPTH; i++) begin
        vld_q[i] <= vld_q[i-1];
      end
    end
  end

  assign pop_valid   = vld_q[DEPTH-1];
  assign pop_payload = stage_q[DEPTH-1];
  assign pop_stamp   = stamp_q;

endmodule

// File: rtl/hetero_wire_link.sv
module hetero_wire_link
  import link_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int FAST_W    = 18,
  parameter int NARROW_W  = 10,
  parameter int RING_MODE = 0,
  parameter int RING_HOPS = 1,
  parameter int TS_W      = 16
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 in_valid,
  output logic                                 in_ready,
  input  logic [KIND_W-1:0]                    in_kind,
  input  logic [DATA_W-1:0]                    in_data,
  input  logic [NUM_CLASSES-1:0]               out_ready,
  output logic [NUM_CLASSES-1:0]               out_valid,
  output logic [NUM_CLASSES-1:0][KIND_W-1:0]   out_kind,
  output logic [NUM_CLASSES-1:0][DATA_W-1:0]   out_data,
  output logic [NUM_CLASSES-1:0][TS_W-1:0]     out_stamp
);

  logic [NUM_CLASSES-1:0] sel_cls;
  logic [NUM_CLASSES-1:0] cls_ready;
  logic [NUM_CLASSES-1:0] cls_push;
  logic [TS_W-1:0]        cycle_q;
  logic [TS_W-1:0]        cycle_next;

  link_steer #(
    .DATA_W  (DATA_W),
    .FAST_W  (FAST_W),
    .NARROW_W(NARROW_W)
  ) steer_i (
    .kind      (in_kind),
    .data      (in_data),
    .cls_onehot(sel_cls)
  );

  assign in_ready = |(sel_cls & cls_ready);
  assign cls_push = sel_cls & {NUM_CLASSES{in_valid && in_ready}};

  assign cycle_next = cycle_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) cycle_q <= '0;
    else     cycle_q <= cycle_next;
  end

  for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_class
    localparam int CW  = (g == CLS_FAST) ? FAST_W : DATA_W;
    localparam int LAT = class_latency(g, RING_MODE != 0, RING_HOPS);
    localparam int PW  = CW + KIND_W;

    logic [PW-1:0] pipe_in;
    logic [PW-1:0] pipe_out;

    assign pipe_in = {in_kind, in_data[CW-1:0]};

    link_class_pipe #(
      .W    (PW),
      .DEPTH(LAT),
      .TS_W (TS_W)
    ) pipe_i (
      .clk         (clk),
      .rst         (rst),
      .push        (cls_push[g]),
      .push_payload(pipe_in),
      .now_next    (cycle_next),
      .pop_ready   (out_ready[g]),
      .can_accept  (cls_ready[g]),
      .pop_valid   (out_valid[g]),
      .pop_payload (pipe_out),
      .pop_stamp   (out_stamp[g])
    );

    assign out_kind[g] = pipe_out[PW-1:CW];
    assign out_data[g] = DATA_W'(pipe_out[CW-1:0]);
  end

endmodule

// File: rtl/hetero_wire_link_chk.sv
module hetero_wire_link_chk
  import link_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int FAST_W    = 18,
  parameter int TS_W      = 16
) (
  input logic                               clk,
  input logic                               rst,
  input logic                               in_ready,
  input logic [NUM_CLASSES-1:0]             out_ready,
  input logic [NUM_CLASSES-1:0]             out_valid,
  input logic [NUM_CLASSES-1:0][KIND_W-1:0] out_kind,
  input logic [NUM_CLASSES-1:0][DATA_W-1:0] out_data,
  input logic [NUM_CLASSES-1:0][TS_W-1:0]   out_stamp
);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_valid == '0));

  assert_fast_kinds_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid[CLS_FAST] |-> (out_kind[CLS_FAST] == 3'd1 || out_kind[CLS_FAST] == 3'd2));

  assert_slow_kinds_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid[CLS_SLOW] |-> (out_kind[CLS_SLOW] == 3'd3 || out_kind[CLS_SLOW] == 3'd4));

  assert_base_kinds_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid[CLS_BASE] |-> (out_kind[CLS_BASE] != 3'd3 && out_kind[CLS_BASE] != 3'd4));

  assert_fast_width_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid[CLS_FAST] |-> ((out_data[CLS_FAST] >> FAST_W) == '0));

  assert_hold_off_R10: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> ((out_valid & ~out_ready) != '0));

  for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_hold
    assert_lane_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (out_valid[g] && !out_ready[g]) |=>
        (out_valid[g] && $stable(out_data[g]) && $stable(out_kind[g]) && $stable(out_stamp[g])));
  end

endmodule

bind hetero_wire_link hetero_wire_link_chk #(
  .DATA_W(DATA_W),
  .FAST_W(FAST_W),
  .TS_W  (TS_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .in_ready (in_ready),
  .out_ready(out_ready),
  .out_valid(out_valid),
  .out_kind (out_kind),
  .out_data (out_data),
  .out_stamp(out_stamp)
);

// File: tb/hetero_wire_link_tb_top.sv
module hetero_wire_link_tb_top;

  localparam int DW   = 64;
  localparam int TSW  = 16;
  localparam int HOPS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [2:0] in_kind = 3'd0;
  logic [DW-1:0] in_data = '0;
  logic [2:0] ready_x = 3'b111;
  logic [2:0] ready_r = 3'b111;

  logic in_ready_x, in_ready_r;
  logic [2:0] valid_x, valid_r;
  logic [2:0][2:0] kind_x, kind_r;
  logic [2:0][DW-1:0] data_x, data_r;
  logic [2:0][TSW-1:0] stamp_x, stamp_r;

  int checks = 0;
  int failures = 0;
  logic [TSW-1:0] tcnt = '0;

  always #10 clk = ~clk;

  always @(posedge clk) tcnt <= rst ? '0 : tcnt + 1'b1;

  hetero_wire_link #(.DATA_W(DW), .RING_MODE(0), .TS_W(TSW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready_x),
    .in_kind(in_kind), .in_data(in_data), .out_ready(ready_x),
    .out_valid(valid_x), .out_kind(kind_x), .out_data(data_x), .out_stamp(stamp_x));

  hetero_wire_link #(.DATA_W(DW), .RING_MODE(1), .RING_HOPS(HOPS), .TS_W(TSW)) dut_ring_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready_r),
    .in_kind(in_kind), .in_data(in_data), .out_ready(ready_r),
    .out_valid(valid_r), .out_kind(kind_r), .out_data(data_r), .out_stamp(stamp_r));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_lane(input logic [2:0] k, input logic [63:0] d);
    if (k == 3'd1) return (d < 64'd1024) ? 0 : 1;
    if (k == 3'd2) return (d < 64'd262144) ? 0 : 1;
    if (k == 3'd3 || k == 3'd4) return 2;
    return 1;
  endfunction

  // One isolated transfer; measure lane, latency, payload, kind and stamp on both builds.
  task automatic xfer(input logic [2:0] k, input logic [63:0] d);
    int el, lx, lr, gotx, gotr;
    string rq;
    el = exp_lane(k, d);
    lx = el + 1;
    lr = (el + 1) * 2 * HOPS;
    gotx = 0;
    gotr = 0;
    rq = (k == 3'd1) ? "R2" : (k == 3'd2) ? "R3" : "R4";
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_data = d;
    chk(in_ready_x == 1'b1, "R9 idle accept", 64'(in_ready_x), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    for (int n = 1; n <= 14; n++) begin
      if (n > 1) @(negedge clk);
      for (int c = 0; c < 3; c++) begin
        if (valid_x[c]) begin
          chk(gotx == 0, "R5 single arrival", 64'(gotx), 64'd0);
          gotx = n;
          chk(c == el, rq, 64'(c), 64'(el));
          chk(n == lx, "R5 latency", 64'(n), 64'(lx));
          chk(data_x[c] == d, "R7 data", data_x[c], d);
          chk(kind_x[c] == k, "R7 kind", 64'(kind_x[c]), 64'(k));
          chk(stamp_x[c] == tcnt, "R8 stamp", 64'(stamp_x[c]), 64'(tcnt));
        end
        if (valid_r[c]) begin
          chk(gotr == 0, "R6 single arrival", 64'(gotr), 64'd0);
          gotr = n;
          chk(c == el, rq, 64'(c), 64'(el));
          chk(n == lr, "R6 latency", 64'(n), 64'(lr));
          chk(data_r[c] == d, "R7 ring data", data_r[c], d);
          chk(stamp_r[c] == tcnt, "R8 ring stamp", 64'(stamp_r[c]), 64'(tcnt));
        end
      end
    end
    chk(gotx != 0, "R5 arrived", 64'(gotx), 64'(lx));
    chk(gotr != 0, "R6 arrived", 64'(gotr), 64'(lr));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] vals [8];
    vals[0] = 64'd0;        vals[1] = 64'd1;
    vals[2] = 64'd1023;     vals[3] = 64'd1024;
    vals[4] = 64'd262143;   vals[5] = 64'd262144;
    vals[6] = 64'h8000_0000_0000_0001;
    vals[7] = 64'hDEAD_BEEF_0123_4567;

    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(valid_x == 3'b000, "R1 valid", 64'(valid_x), 64'd0);
    chk(valid_r == 3'b000, "R1 ring valid", 64'(valid_r), 64'd0);
    chk(in_ready_x == 1'b1, "R1 ready", 64'(in_ready_x), 64'd1);

    // R2 R3 R4 R5 R6 R7 R8: sweep of every kind against boundary payloads
    for (int k = 0; k < 8; k++) begin
      for (int v = 0; v < 8; v++) begin
        xfer(3'(k), vals[v]);
      end
    end

    // R9 R10 R11: stall baseline lane, queue A, B; hold C
    @(negedge clk);
    ready_x[1] = 1'b0;
    in_valid = 1'b1; in_kind = 3'd0; in_data = 64'hA;
    @(negedge clk);
    chk(in_ready_x == 1'b1, "R9 ready before stall", 64'(in_ready_x), 64'd1);
    in_data = 64'hB;
    @(negedge clk);
    in_data = 64'hC;
    chk(valid_x[1] == 1'b1 && data_x[1] == 64'hA, "R9 head A", data_x[1], 64'hA);
    chk(in_ready_x == 1'b0, "R9 held off", 64'(in_ready_x), 64'd0);
    for (int h = 0; h < 3; h++) begin
      @(negedge clk);
      chk(in_ready_x == 1'b0, "R9 still held", 64'(in_ready_x), 64'd0);
      chk(data_x[1] == 64'hA && valid_x[1], "R9 output stable", data_x[1], 64'hA);
      chk(valid_x[0] == 1'b0 && valid_x[2] == 1'b0, "R10 no reroute", 64'(valid_x), 64'b010);
    end
    ready_x[1] = 1'b1;
    #1;
    chk(in_ready_x == 1'b1, "R10 accepted on release", 64'(in_ready_x), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(valid_x[1] && data_x[1] == 64'hB, "R11 order B", data_x[1], 64'hB);
    @(negedge clk);
    chk(valid_x[1] && data_x[1] == 64'hC, "R11 order C", data_x[1], 64'hC);
    @(negedge clk);
    chk(valid_x[1] == 1'b0, "R11 drained", 64'(valid_x[1]), 64'd0);

    // R11: fast transfer sent later overtakes slow one
    repeat (14) @(negedge clk);
    in_valid = 1'b1; in_kind = 3'd3; in_data = 64'h1234;
    @(negedge clk);
    in_kind = 3'd1; in_data = 64'd7;
    @(negedge clk);
    in_valid = 1'b0;
    chk(valid_x[0] && data_x[0] == 64'd7, "R11 fast first", data_x[0], 64'd7);
    chk(valid_x[2] == 1'b0, "R11 slow not yet", 64'(valid_x[2]), 64'd0);
    @(negedge clk);
    chk(valid_x[2] && data_x[2] == 64'h1234, "R11 slow later", data_x[2], 64'h1234);
    chk(valid_x[0] == 1'b0, "R11 fast gone", 64'(valid_x[0]), 64'd0);

    repeat (16) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule